// File: doc/BRIEF.md
# Lock-Step Balancing Controller

This controller coordinates two identical cores so that they can run an original program and its complementary-data twin in exact cycle lock-step. Core A (the primary) raises a start strobe together with the two start addresses. The controller sends a one-cycle external interrupt to core B and waits out the pipeline flush. It then steps core B's context out to its stack one register at a time through a save/restore port. Once the last register is saved, it loads both start addresses into the two cores on the same clock cycle.

When core A raises the end strobe, the controller steps core B's context back in, spends one exit cycle and then reloads core B's interrupted address so that it resumes its own program. Interrupts are tracked per core. Outside a session, finishing an interrupt reloads only the core that serviced it. Inside a session, the partner core is frozen for the duration of the interrupt, and both cores are reloaded together when the interrupt ends.

Top module: `lockstep_balance_ctrl`

## Requirements
- R1: While reset is active, busy, balancing, external interrupt, save/restore activity, both holds and both PC-load strobes are all 0.
- R2: A start strobe accepted in the idle state raises the external interrupt to core B for exactly one cycle, in the cycle after the strobe. In that same cycle busy goes to 1 and both holds (bit 0 = core A, bit 1 = core B) go to 1.
- R3: After the interrupt cycle the controller waits 6 flush cycles with no save activity. It then saves 37 registers in index order 0 to 36 (0–31 register file, 32 PC, 33 HI, 34 LO, 35–36 checksum registers). Each index is presented for 10 consecutive cycles with the restore flag at 0, and both cores stay held.
- R4: In the cycle right after the last save cycle, both PC-load strobes pulse together for one cycle and carry the start addresses sampled with the start strobe. At the same time both holds drop and balancing goes to 1.
- R5: An end strobe during balancing starts a restore pass in the next cycle. The pass uses the same index order and 10-cycle pacing as the save, with the restore flag at 1. Core B is held and core A is not.
- R6: After the restore pass there is one exit cycle (busy 1, core B held, no save activity). In the following cycle only core B's PC-load strobe pulses, carrying the core B address sampled on the last flush edge, and busy drops to 0.
- R7: If a core reports an interrupt taken during balancing, the other core is held from the next cycle until the interrupt ends. An end strobe arriving during this time is ignored, and so is an end-of-interrupt from the held core.
- R8: The end-of-interrupt from the interrupted core during balancing pulses both PC-load strobes in the next cycle. They carry both cores' addresses as sampled when the interrupt was taken, and the holds are released.
- R9: Outside a session, a core's end-of-interrupt pulses only that core's PC-load strobe in the next cycle, carrying the address sampled when it took the interrupt. Neither core is held.
- R10: A start strobe while busy is ignored: no external interrupt, no save activity and no PC load follow from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bal_start_i | input | 1 | Start-balancing strobe from core A |
| bal_end_i | input | 1 | End-balancing strobe from core A |
| start_pc_a_i | input | PC_W | Session start address for core A, sampled with the start strobe |
| start_pc_b_i | input | PC_W | Session start address for core B, sampled with the start strobe |
| core_pc_a_i | input | PC_W | Current resume address of core A |
| core_pc_b_i | input | PC_W | Current resume address of core B |
| irq_take_i | input | 2 | Per-core strobe: interrupt taken (bit 0 core A) |
| eoi_i | input | 2 | Per-core non-maskable end-of-interrupt strobe |
| ext_irq_o | output | 1 | Maskable external interrupt to core B |
| pc_load_o | output | 2 | Per-core PC-load strobe |
| pc_a_o | output | PC_W | Address loaded into core A |
| pc_b_o | output | PC_W | Address loaded into core B |
| hold_o | output | 2 | Per-core hold (freeze) |
| sr_active_o | output | 1 | A save or restore step is in progress |
| sr_restore_o | output | 1 | 1 = restoring, 0 = saving |
| sr_index_o | output | IDX_W | Index of the register being moved |
| busy_o | output | 1 | Controller is outside idle |
| balancing_o | output | 1 | A lock-step session is running |

## Verification
Almost every internal error in this controller becomes visible as a timing shift at the ports. A miscounted flush or per-register counter moves the first save cycle or the paired PC load by at least one cycle, and the bench samples those exact cycles. A wrong captured address appears as a wrong value on the PC-load bus in the cycle of the load. A wrong owner or state shows up at once, within one cycle of the triggering strobe, as a wrong hold pattern or as a lone load strobe during a session.

// File: rtl/lockstep_balance_ctrl.sv
module lockstep_balance_ctrl #(
  parameter int PC_W      = 32,
  parameter int FLUSH_CYC = 6,
  parameter int REG_CYC   = 10,
  parameter int RF_REGS   = 32,
  parameter int SPR_REGS  = 3,
  parameter int SIG_REGS  = 2,
  parameter int IDX_W     = $clog2(RF_REGS + SPR_REGS + SIG_REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bal_start_i,
  input  logic            bal_end_i,
  input  logic [PC_W-1:0] start_pc_a_i,
  input  logic [PC_W-1:0] start_pc_b_i,
  input  logic [PC_W-1:0] core_pc_a_i,
  input  logic [PC_W-1:0] core_pc_b_i,
  input  logic [1:0]      irq_take_i,
  input  logic [1:0]      eoi_i,
  output logic            ext_irq_o,
  output logic [1:0]      pc_load_o,
  output logic [PC_W-1:0] pc_a_o,
  output logic [PC_W-1:0] pc_b_o,
  output logic [1:0]      hold_o,
  output logic            sr_active_o,
  output logic            sr_restore_o,
  output logic [IDX_W-1:0] sr_index_o,
  output logic            busy_o,
  output logic            balancing_o
);
  localparam int NREGS = RF_REGS + SPR_REGS + SIG_REGS;
  localparam int CMAX  = (REG_CYC > FLUSH_CYC) ? REG_CYC : FLUSH_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_CYC - 1);
  localparam logic [CNT_W-1:0] REG_LAST   = CNT_W'(REG_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NREGS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_INTR, S_FLUSH, S_SAVE, S_BAL, S_BAL_IRQ, S_RESTORE, S_EXIT
  } state_t;

  state_t                 st;
  logic [CNT_W-1:0]       cnt;
  logic [IDX_W-1:0]       idx;
  logic                   owner;
  logic [1:0]             in_isr;
  logic [1:0][PC_W-1:0]   tgt;
  logic [1:0][PC_W-1:0]   rsm;
  logic [1:0][PC_W-1:0]   pc_q;
  logic [PC_W-1:0]        keep_b;
  logic [1:0]             load_q;
  logic [1:0][PC_W-1:0]   core_pc;

  assign core_pc = {core_pc_b_i, core_pc_a_i};
  wire step_last = (cnt == REG_LAST);
  wire seq_last  = step_last && (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      owner  <= 1'b0;
      in_isr <= '0;
      tgt    <= '0;
      rsm    <= '0;
      pc_q   <= '0;
      keep_b <= '0;
      load_q <= '0;
    end else begin
      load_q <= '0;
      case (st)
        S_IDLE: begin
          if (bal_start_i) begin
            tgt    <= {start_pc_b_i, start_pc_a_i};
            in_isr <= '0;
            st     <= S_INTR;
          end else begin
            for (int k = 0; k < 2; k++) begin
              if (in_isr[k] && eoi_i[k]) begin
                load_q[k] <= 1'b1;
                pc_q[k]   <= rsm[k];
                in_isr[k] <= 1'b0;
              end else if (!in_isr[k] && irq_take_i[k]) begin
                rsm[k]    <= core_pc[k];
                in_isr[k] <= 1'b1;
              end
            end
          end
        end
        S_INTR: begin
          cnt <= '0;
          st  <= S_FLUSH;
        end
        S_FLUSH: begin
          if (cnt == FLUSH_LAST) begin
            cnt    <= '0;
            idx    <= '0;
            keep_b <= core_pc_b_i;
            st     <= S_SAVE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SAVE, S_RESTORE: begin
          if (step_last) begin
            cnt <= '0;
            if (seq_last) begin
              idx <= '0;
              if (st == S_SAVE) begin
                load_q <= 2'b11;
                pc_q   <= tgt;
                st     <= S_BAL;
              end else begin
                st <= S_EXIT;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BAL: begin
          if (irq_take_i != 2'b00) begin
            owner <= !irq_take_i[0];
            rsm   <= core_pc;
            st    <= S_BAL_IRQ;
          end else if (bal_end_i) begin
            cnt <= '0;
            idx <= '0;
            st  <= S_RESTORE;
          end
        end
        S_BAL_IRQ: begin
          if (eoi_i[owner]) begin
            load_q <= 2'b11;
            pc_q   <= rsm;
            st     <= S_BAL;
          end
        end
        S_EXIT: begin
          load_q[1] <= 1'b1;
          pc_q[1]   <= keep_b;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_INTR, S_FLUSH, S_SAVE: hold_o = 2'b11;
      S_BAL_IRQ:               hold_o = owner ? 2'b01 : 2'b10;
      S_RESTORE, S_EXIT:       hold_o = 2'b10;
      default:                 hold_o = 2'b00;
    endcase
  end

  assign ext_irq_o    = (st == S_INTR);
  assign sr_active_o  = (st == S_SAVE) || (st == S_RESTORE);
  assign sr_restore_o = (st == S_RESTORE);
  assign sr_index_o   = idx;
  assign busy_o       = (st != S_IDLE);
  assign balancing_o  = (st == S_BAL) || (st == S_BAL_IRQ);
  assign pc_load_o    = load_q;
  assign pc_a_o       = pc_q[0];
  assign pc_b_o       = pc_q[1];
endmodule

module lockstep_balance_ctrl_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_irq_o,
  input logic             busy_o,
  input logic             sr_active_o,
  input logic             sr_restore_o,
  input logic [IDX_W-1:0] sr_index_o,
  input logic [1:0]       pc_load_o,
  input logic [1:0]       hold_o
);
  // R2
  ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_o |=> !ext_irq_o);

  // R10
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_o |-> !$past(busy_o));

  // R3
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_active_o && $past(sr_active_o)) |->
      ((sr_index_o == $past(sr_index_o)) || (sr_index_o == $past(sr_index_o) + 1'b1)));

  // R5
  restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_active_o && sr_restore_o) |-> (hold_o == 2'b10));

  // R4
  paired_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (pc_load_o != 2'b00)) |-> (pc_load_o == 2'b11));

  // R9
  idle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (hold_o == 2'b00));
endmodule

bind lockstep_balance_ctrl lockstep_balance_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_irq_o(ext_irq_o), .busy_o(busy_o),
  .sr_active_o(sr_active_o), .sr_restore_o(sr_restore_o), .sr_index_o(sr_index_o),
  .pc_load_o(pc_load_o), .hold_o(hold_o)
);

// File: tb/lockstep_balance_ctrl_test.sv
`timescale 1ns/1ps
module lockstep_balance_ctrl_test;
  localparam int PC_W  = 32;
  localparam int NREGS = 37;
  localparam int RCYC  = 10;
  localparam int FCYC  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bal_start_i = 1'b0, bal_end_i = 1'b0;
  logic [PC_W-1:0] start_pc_a_i = '0, start_pc_b_i = '0;
  logic [PC_W-1:0] core_pc_a_i = '0, core_pc_b_i = '0;
  logic [1:0]      irq_take_i = '0, eoi_i = '0;
  logic            ext_irq_o;
  logic [1:0]      pc_load_o, hold_o;
  logic [PC_W-1:0] pc_a_o, pc_b_o;
  logic            sr_active_o, sr_restore_o, busy_o, balancing_o;
  logic [5:0]      sr_index_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lockstep_balance_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bal_start_i(bal_start_i), .bal_end_i(bal_end_i),
    .start_pc_a_i(start_pc_a_i), .start_pc_b_i(start_pc_b_i),
    .core_pc_a_i(core_pc_a_i), .core_pc_b_i(core_pc_b_i),
    .irq_take_i(irq_take_i), .eoi_i(eoi_i), .ext_irq_o(ext_irq_o),
    .pc_load_o(pc_load_o), .pc_a_o(pc_a_o), .pc_b_o(pc_b_o), .hold_o(hold_o),
    .sr_active_o(sr_active_o), .sr_restore_o(sr_restore_o), .sr_index_o(sr_index_o),
    .busy_o(busy_o), .balancing_o(balancing_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // core, interrupted address, cycles spent in the handler
  localparam logic [40:0] VEC [0:3] = '{
    {1'b0, 32'h0000_1000, 8'd3},
    {1'b1, 32'h0000_2220, 8'd1},
    {1'b0, 32'h0000_3FFC, 8'd12},
    {1'b1, 32'hFFFF_FFF0, 8'd5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) tick;
    // R1 reset state
    chk(!busy_o && !balancing_o && !ext_irq_o && !sr_active_o && hold_o == 2'b00 && pc_load_o == 2'b00,
        "R1", {busy_o, balancing_o, ext_irq_o, sr_active_o, hold_o, pc_load_o}, 0);
    rst_n = 1'b1;
    tick;

    // R9 interrupts outside a session, from the vector table
    for (int i = 0; i < 4; i++) begin
      logic        c;
      logic [31:0] pv;
      int          gap;
      c   = VEC[i][40];
      pv  = VEC[i][39:8];
      gap = int'(VEC[i][7:0]);
      if (c) core_pc_b_i = pv; else core_pc_a_i = pv;
      irq_take_i[c] = 1'b1;
      tick;
      irq_take_i = '0;
      core_pc_a_i = 32'hDEAD_0000;
      core_pc_b_i = 32'hBEEF_0000;
      ok = 1'b1;
      repeat (gap) begin
        tick;
        ok &= (hold_o == 2'b00) && (pc_load_o == 2'b00);
      end
      eoi_i[c] = 1'b1;
      tick;
      eoi_i = '0;
      ok &= (pc_load_o == (c ? 2'b10 : 2'b01)) && ((c ? pc_b_o : pc_a_o) == pv) && (hold_o == 2'b00);
      chk(ok, "R9", {pc_load_o, (c ? pc_b_o : pc_a_o)}, {(c ? 2'b10 : 2'b01), pv});
      tick;
    end

    // R2 start of a session
    core_pc_a_i  = 32'h0000_0A00;
    core_pc_b_i  = 32'h0000_4400;
    start_pc_a_i = 32'h0001_0000;
    start_pc_b_i = 32'h0002_0000;
    bal_start_i  = 1'b1;
    tick;
    bal_start_i  = 1'b0;
    start_pc_a_i = 32'h0BAD_0001;
    start_pc_b_i = 32'h0BAD_0002;
    chk(ext_irq_o && busy_o && hold_o == 2'b11, "R2", {ext_irq_o, busy_o, hold_o}, 4'b1111);

    // R3 flush window
    ok = 1'b1;
    for (int j = 0; j < FCYC; j++) begin
      tick;
      ok &= !ext_irq_o && !sr_active_o && hold_o == 2'b11;
    end
    chk(ok, "R3 flush", {ext_irq_o, sr_active_o, hold_o}, 4'b0011);

    // R3 save order and pacing
    ok = 1'b1;
    for (int j = 0; j < NREGS * RCYC; j++) begin
      tick;
      ok &= sr_active_o && !sr_restore_o && (int'(sr_index_o) == j / RCYC) &&
            hold_o == 2'b11 && pc_load_o == 2'b00;
    end
    chk(ok, "R3 save", sr_index_o, NREGS - 1);
    core_pc_b_i = 32'h5555_0000;

    // R4 paired start load
    tick;
    chk(pc_load_o == 2'b11 && pc_a_o == 32'h0001_0000 && pc_b_o == 32'h0002_0000 &&
        hold_o == 2'b00 && balancing_o, "R4", {pc_load_o, pc_a_o, pc_b_o}, {2'b11, 32'h0001_0000, 32'h0002_0000});
    tick;
    chk(pc_load_o == 2'b00 && balancing_o, "R4 single pulse", pc_load_o, 0);

    // R10 start while busy
    start_pc_a_i = 32'h0777_0000;
    bal_start_i  = 1'b1;
    tick;
    bal_start_i  = 1'b0;
    ok = !ext_irq_o && busy_o && balancing_o;
    repeat (400) begin
      tick;
      ok &= !ext_irq_o && pc_load_o == 2'b00 && !sr_active_o && hold_o == 2'b00;
    end
    chk(ok, "R10", {ext_irq_o, pc_load_o, sr_active_o}, 0);

    // R7 core A interrupted during the session
    core_pc_a_i = 32'h0001_0040;
    core_pc_b_i = 32'h0002_0040;
    irq_take_i  = 2'b01;
    tick;
    irq_take_i  = '0;
    core_pc_a_i = 32'h0000_0100;
    core_pc_b_i = 32'h0000_0200;
    chk(hold_o == 2'b10 && balancing_o, "R7 hold B", hold_o, 2'b10);
    bal_end_i = 1'b1;
    tick;
    bal_end_i = 1'b0;
    eoi_i = 2'b10;
    tick;
    eoi_i = '0;
    ok = 1'b1;
    repeat (5) begin
      tick;
      ok &= busy_o && balancing_o && !sr_active_o && hold_o == 2'b10 && pc_load_o == 2'b00;
    end
    chk(ok, "R7 ignored strobes", {sr_active_o, hold_o, pc_load_o}, 5'b01000);

    // R8 resume both together
    eoi_i = 2'b01;
    tick;
    eoi_i = '0;
    chk(pc_load_o == 2'b11 && pc_a_o == 32'h0001_0040 && pc_b_o == 32'h0002_0040 && hold_o == 2'b00,
        "R8 core A", {pc_load_o, pc_a_o, pc_b_o}, {2'b11, 32'h0001_0040, 32'h0002_0040});
    tick;

    // R7 / R8 core B interrupted
    core_pc_a_i = 32'h0001_0080;
    core_pc_b_i = 32'h0002_0080;
    irq_take_i  = 2'b10;
    tick;
    irq_take_i  = '0;
    core_pc_a_i = 32'h0000_0300;
    core_pc_b_i = 32'h0000_0400;
    chk(hold_o == 2'b01, "R7 hold A", hold_o, 2'b01);
    repeat (3) tick;
    eoi_i = 2'b10;
    tick;
    eoi_i = '0;
    chk(pc_load_o == 2'b11 && pc_a_o == 32'h0001_0080 && pc_b_o == 32'h0002_0080 && hold_o == 2'b00,
        "R8 core B", {pc_load_o, pc_a_o, pc_b_o}, {2'b11, 32'h0001_0080, 32'h0002_0080});
    tick;

    // R5 restore pass
    bal_end_i = 1'b1;
    tick;
    bal_end_i = 1'b0;
    ok = 1'b1;
    for (int j = 0; j < NREGS * RCYC; j++) begin
      ok &= sr_active_o && sr_restore_o && (int'(sr_index_o) == j / RCYC) && hold_o == 2'b10;
      tick;
    end
    chk(ok, "R5", {sr_active_o, sr_restore_o, hold_o}, 4'b1110);

    // R6 exit cycle then core B resume
    chk(busy_o && !sr_active_o && hold_o == 2'b10 && pc_load_o == 2'b00, "R6 exit",
        {busy_o, sr_active_o, hold_o, pc_load_o}, 6'b101000);
    tick;
    chk(pc_load_o == 2'b10 && pc_b_o == 32'h0000_4400 && !busy_o && hold_o == 2'b00, "R6 resume",
        {pc_load_o, pc_b_o}, {2'b10, 32'h0000_4400});
    tick;
    chk(pc_load_o == 2'b00 && !busy_o && !balancing_o, "R6 idle", {pc_load_o, busy_o}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule